// File: doc/BRIEF.md
# Control Word Decoder and Mode Register

This block sits behind a serial slave port. The slave hands it a committed 16-bit control word with a one-cycle valid strobe. The decoder checks the word and, if the word is legal, does three things. It writes the operating mode carried in the word. It updates the four switch enables. It routes the payload field to one of the configuration targets that the configuration select field picks: the cyclic wake timing plus the monitor enable, the watchdog window timing, or a watchdog trigger. All results are registered and appear on the clock edge that samples the strobe.

The block also enforces the operating rules of the device. A word with a bad target, a bad mode code or the reserved bit set has no effect. Switches stay off in the low-power modes. After a stay in a low-power mode, the switches can be enabled only by a word that follows an accepted Active-mode word. A wake event in a low-power mode raises a wake-pending flag. A soft reset, caused by undervoltage or the watchdog, restores the defaults but keeps the wake timing and the monitor enable. The power-on reset clears everything.

Word layout: bits 15:14 are the configuration select, bits 13:11 the mode, bits 10:5 the payload field, bit 4 the reserved bit, and bits 3:0 the switch enables.

Top module: `ctl_word_decoder`

## Requirements
- R1: After power-on reset, mode_o is 001 (Active), wake_pend_o is 0, sw_en_o is 0, win_time_o is all ones, wake_time_o is WAKE_RST (default 0), mon_en_o is 0 and wd_trig_o is 0.
- R2: A valid word is ignored, and leaves every output unchanged with no trigger, in any of these cases: the select (bits 15:14) is 00; the mode (bits 13:11) is 000, 100 or 101; the reserved bit 4 is 1.
- R3: An accepted word with select 01 loads wake_time_o from bits 9:5 and mon_en_o from bit 10, and leaves win_time_o unchanged.
- R4: An accepted word with select 10 loads win_time_o from bits 10:5, and leaves wake_time_o and mon_en_o unchanged.
- R5: An accepted word with select 11 makes wd_trig_o high for exactly the one cycle after the word, and changes no configuration output. wd_trig_o is 0 in every other cycle.
- R6: Every accepted word sets mode_o to its mode field and clears wake_pend_o. All outputs change on the clock edge that samples cw_valid.
- R7: When the switches are armed and the new mode is not a low-power mode, an accepted word loads sw_en_o from bits 3:0. The bit order is 0 supply output, 1 high-side/LED, 2 low-side 1, 3 low-side 2.
- R8: An accepted word whose mode is low-power (010, 011 or 111) turns all switch enables off and disarms the switches.
- R9: A wake_evt while mode_o is a low-power mode, in a cycle with no accepted word, sets wake_pend_o. A wake_evt in mode 001 or 110 has no effect. An accepted word in the same cycle takes precedence over the wake event.
- R10: While disarmed, an accepted Active-mode word sets mode 001 and arms the switches, but sw_en_o stays 0. The next accepted word applies its switch bits. An accepted word with mode 110 while disarmed leaves sw_en_o at 0.
- R11: A soft_rst sets mode 001, clears sw_en_o and wake_pend_o, arms the switches, sets win_time_o to all ones and clears wd_trig_o. It keeps wake_time_o and mon_en_o, and it overrides a word presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Undervoltage or watchdog reset; keeps the retained fields |
| wake_evt | input | 1 | Wake event from a wake source |
| cw_valid | input | 1 | One-cycle strobe marking a committed control word |
| cw | input | 16 | Control word |
| mode_o | output | 3 | Current mode code |
| wake_pend_o | output | 1 | Wake received, waiting for an Active-mode word |
| sw_en_o | output | 4 | Switch enables |
| wake_time_o | output | 5 | Cyclic wake timing (retained) |
| mon_en_o | output | 1 | Monitor enable (retained) |
| win_time_o | output | 6 | Watchdog window timing |
| wd_trig_o | output | 1 | Watchdog trigger pulse |

## Verification
The bench builds the block with its default parameter values. With the fixed 16-bit layout, this covers every select code and every mode code. It also sets WAKE_RST to 0, so the bench can tell a retained wake timing after a soft reset apart from a reloaded default. A soft reset that follows a nonzero wake timing therefore shows directly whether the retention rule holds.

// File: rtl/ctlw_pkg.sv
package ctlw_pkg;
  localparam int CW_W     = 16;
  localparam int SEL_W    = 2;
  localparam int MODE_W   = 3;
  localparam int FLD_W    = 6;
  localparam int SW_W     = 4;
  localparam int WAKE_W   = 5;
  localparam int WIN_W    = FLD_W;
  localparam int SEL_LSB  = CW_W - SEL_W;
  localparam int MODE_LSB = SEL_LSB - MODE_W;
  localparam int FLD_LSB  = MODE_LSB - FLD_W;
  localparam int RSV_BIT  = SW_W;
  localparam int MON_BIT  = FLD_W - 1;

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [SEL_W-1:0]  sel_t;

  localparam mode_t M_ACTIVE = 3'b001;
  localparam mode_t M_LSLEEP = 3'b010;
  localparam mode_t M_SLEEP  = 3'b011;
  localparam mode_t M_RXONLY = 3'b110;
  localparam mode_t M_STOP   = 3'b111;

  localparam sel_t S_NONE = 2'b00;
  localparam sel_t S_WAKE = 2'b01;
  localparam sel_t S_WIN  = 2'b10;
  localparam sel_t S_TRIG = 2'b11;

  function automatic logic mode_legal(mode_t m);
    return (m == M_ACTIVE) || (m == M_LSLEEP) || (m == M_SLEEP) ||
           (m == M_RXONLY) || (m == M_STOP);
  endfunction

  function automatic logic mode_low(mode_t m);
    return (m == M_LSLEEP) || (m == M_SLEEP) || (m == M_STOP);
  endfunction
endpackage

// File: rtl/cw_decode.sv
module cw_decode
  import ctlw_pkg::*;
(
  input  logic [CW_W-1:0]  cw,
  output logic             ok,
  output sel_t             sel,
  output mode_t            mode,
  output logic [FLD_W-1:0] fld,
  output logic [SW_W-1:0]  sw
);
  logic rsv;

  always_comb begin
    sel  = cw[SEL_LSB +: SEL_W];
    mode = cw[MODE_LSB +: MODE_W];
    fld  = cw[FLD_LSB +: FLD_W];
    rsv  = cw[RSV_BIT];
    sw   = cw[SW_W-1:0];
    ok   = (sel != S_NONE) && mode_legal(mode) && !rsv;
  end
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import ctlw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            wake_evt,
  input  logic            acc,
  input  mode_t           mode_in,
  input  logic [SW_W-1:0] sw_in,
  output mode_t           mode_q,
  output logic            pend_q,
  output logic [SW_W-1:0] sw_q,
  output logic            armed_q
);
  logic wake_take;

  assign wake_take = wake_evt && !acc && !soft_rst && mode_low(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_ACTIVE;
      pend_q  <= 1'b0;
      sw_q    <= '0;
      armed_q <= 1'b1;
    end else if (soft_rst) begin
      mode_q  <= M_ACTIVE;
      pend_q  <= 1'b0;
      sw_q    <= '0;
      armed_q <= 1'b1;
    end else if (acc) begin
      mode_q <= mode_in;
      pend_q <= 1'b0;
      if (mode_low(mode_in)) begin
        sw_q    <= '0;
        armed_q <= 1'b0;
      end else begin
        sw_q <= armed_q ? sw_in : '0;
        if (mode_in == M_ACTIVE) armed_q <= 1'b1;
      end
    end else if (wake_take) begin
      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import ctlw_pkg::*;
#(
  parameter logic [WAKE_W-1:0] WAKE_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              acc,
  input  sel_t              sel,
  input  logic [FLD_W-1:0]  fld,
  output logic [WAKE_W-1:0] wake_q,
  output logic              mon_q,
  output logic [WIN_W-1:0]  win_q,
  output logic              trig_q
);
  // retained group: only power-on reset clears it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= WAKE_RST;
      mon_q  <= 1'b0;
    end else if (acc && sel == S_WAKE) begin
      wake_q <= fld[WAKE_W-1:0];
      mon_q  <= fld[MON_BIT];
    end
  end

  // volatile group: soft reset restores defaults
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '1;
      trig_q <= 1'b0;
    end else if (soft_rst) begin
      win_q  <= '1;
      trig_q <= 1'b0;
    end else begin
      trig_q <= acc && (sel == S_TRIG);
      if (acc && sel == S_WIN) win_q <= fld;
    end
  end
endmodule

// File: rtl/ctl_word_decoder.sv
module ctl_word_decoder
  import ctlw_pkg::*;
#(
  parameter logic [4:0] WAKE_RST = 5'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        wake_evt,
  input  logic        cw_valid,
  input  logic [15:0] cw,
  output logic [2:0]  mode_o,
  output logic        wake_pend_o,
  output logic [3:0]  sw_en_o,
  output logic [4:0]  wake_time_o,
  output logic        mon_en_o,
  output logic [5:0]  win_time_o,
  output logic        wd_trig_o
);
  logic             cmd_ok_w;
  sel_t             sel_w;
  mode_t            mode_w;
  logic [FLD_W-1:0] fld_w;
  logic [SW_W-1:0]  sw_w;
  logic             acc_w;
  logic             armed_w;
  mode_t            mode_q_w;

  cw_decode u_dec (
    .cw(cw), .ok(cmd_ok_w), .sel(sel_w), .mode(mode_w), .fld(fld_w), .sw(sw_w)
  );

  assign acc_w = cw_valid && cmd_ok_w && !soft_rst;

  mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wake_evt(wake_evt),
    .acc(acc_w), .mode_in(mode_w), .sw_in(sw_w),
    .mode_q(mode_q_w), .pend_q(wake_pend_o), .sw_q(sw_en_o), .armed_q(armed_w)
  );

  assign mode_o = mode_q_w;

  cfg_regs #(.WAKE_RST(WAKE_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .acc(acc_w),
    .sel(sel_w), .fld(fld_w),
    .wake_q(wake_time_o), .mon_q(mon_en_o), .win_q(win_time_o), .trig_q(wd_trig_o)
  );
endmodule

// File: rtl/ctl_word_decoder_chk.sv
module ctl_word_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       wake_evt,
  input logic       cw_valid,
  input logic       cmd_ok,
  input logic [1:0] sel,
  input logic [2:0] mode_o,
  input logic       wake_pend_o,
  input logic [3:0] sw_en_o,
  input logic [4:0] wake_time_o,
  input logic       mon_en_o,
  input logic [5:0] win_time_o,
  input logic       wd_trig_o
);
  logic low_now;
  logic trig_cmd;
  assign low_now  = (mode_o == 3'b010) || (mode_o == 3'b011) || (mode_o == 3'b111);
  assign trig_cmd = cw_valid && cmd_ok && !soft_rst && (sel == 2'b11);

  // R8
  low_sw_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_now |-> (sw_en_o == 4'b0));

  // R2
  ignored_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && !cmd_ok && !soft_rst && !wake_evt) |=>
      ($stable(mode_o) && $stable(sw_en_o) && $stable(win_time_o) &&
       $stable(wake_time_o) && $stable(mon_en_o) && $stable(wake_pend_o) && !wd_trig_o));

  // R5
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_cmd |=> wd_trig_o);

  // R5
  trig_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_cmd |=> !wd_trig_o);

  // R11
  retain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ($stable(wake_time_o) && $stable(mon_en_o) && mode_o == 3'b001 &&
                  sw_en_o == 4'b0 && win_time_o == 6'h3f));

  // R10
  disarmed_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pend_o && cw_valid && cmd_ok && !soft_rst) |=> (sw_en_o == 4'b0 && !wake_pend_o));
endmodule

bind ctl_word_decoder ctl_word_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wake_evt(wake_evt),
  .cw_valid(cw_valid), .cmd_ok(cmd_ok_w), .sel(sel_w),
  .mode_o(mode_o), .wake_pend_o(wake_pend_o), .sw_en_o(sw_en_o),
  .wake_time_o(wake_time_o), .mon_en_o(mon_en_o), .win_time_o(win_time_o),
  .wd_trig_o(wd_trig_o)
);

// File: tb/tb_ctl_word_decoder.sv
`timescale 1ns/1ps
module tb_ctl_word_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, wake_evt = 1'b0, cw_valid = 1'b0;
  logic [15:0] cw = '0;
  logic [2:0] mode_o;
  logic wake_pend_o, mon_en_o, wd_trig_o;
  logic [3:0] sw_en_o;
  logic [4:0] wake_time_o;
  logic [5:0] win_time_o;

  always #4 clk = ~clk;

  ctl_word_decoder dut (.*);

  typedef struct packed {
    logic [2:0] mode; logic pend; logic [3:0] sw; logic [4:0] wake;
    logic mon; logic [5:0] win; logic trig;
  } obs_t;

  obs_t exp_q[$];
  string tag_q[$];
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  logic [2:0] m_mode = 3'b001;
  logic m_pend = 1'b0, m_arm = 1'b1, m_mon = 1'b0, m_trig = 1'b0;
  logic [3:0] m_sw = '0;
  logic [4:0] m_wake = '0;
  logic [5:0] m_win = 6'h3f;

  function automatic logic [15:0] mk(logic [1:0] s, logic [2:0] m, logic [5:0] f,
                                     logic r, logic [3:0] w);
    return {s, m, f, r, w};
  endfunction

  function automatic bit is_low(logic [2:0] m);
    return m == 3'b010 || m == 3'b011 || m == 3'b111;
  endfunction

  function automatic bit word_ok(logic [15:0] w);
    logic [2:0] m = w[13:11];
    return w[15:14] != 2'b00 && !w[4] &&
           (m == 3'b001 || m == 3'b010 || m == 3'b011 || m == 3'b110 || m == 3'b111);
  endfunction

  task automatic step(input logic s_rst, input logic wk, input logic v,
                      input logic [15:0] w, input string tag);
    obs_t e;
    @(negedge clk);
    soft_rst = s_rst; wake_evt = wk; cw_valid = v; cw = w;
    m_trig = 1'b0;
    if (s_rst) begin
      m_mode = 3'b001; m_pend = 1'b0; m_arm = 1'b1; m_sw = '0; m_win = 6'h3f;
    end else if (v && word_ok(w)) begin
      m_mode = w[13:11]; m_pend = 1'b0;
      if (is_low(w[13:11])) begin m_sw = '0; m_arm = 1'b0; end
      else begin
        m_sw = m_arm ? w[3:0] : 4'b0;
        if (w[13:11] == 3'b001) m_arm = 1'b1;
      end
      case (w[15:14])
        2'b01: begin m_wake = w[9:5]; m_mon = w[10]; end
        2'b10: m_win = w[10:5];
        2'b11: m_trig = 1'b1;
        default: ;
      endcase
    end else if (wk && is_low(m_mode)) begin
      m_pend = 1'b1;
    end
    e = '{m_mode, m_pend, m_sw, m_wake, m_mon, m_win, m_trig};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 1'b0, 16'h0, tag);
  endtask

  initial begin : monitor
    obs_t a, e;
    string t;
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        a = '{mode_o, wake_pend_o, sw_en_o, wake_time_o, mon_en_o, win_time_o, wd_trig_o};
        n_chk++;
        if (a !== e) begin
          n_err++;
          $display("FAIL %s: actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  initial begin : watchdog
    #800000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    // R7 R3: Active, wake config, switches 0101
    step(0, 0, 1, mk(2'b01, 3'b001, {1'b1, 5'h0a}, 0, 4'b0101), "R7 R3 wake cfg and switches");
    step(0, 0, 1, mk(2'b10, 3'b001, 6'h12, 0, 4'b1111), "R4 window load");
    step(0, 0, 1, mk(2'b11, 3'b001, 6'h3f, 0, 4'b0011), "R5 trigger pulse");
    idle("R5 trigger drops");
    // R2 ignored words
    step(0, 0, 1, mk(2'b00, 3'b001, 6'h01, 0, 4'b0000), "R2 select 00");
    step(0, 0, 1, mk(2'b10, 3'b100, 6'h01, 0, 4'b0000), "R2 mode 100");
    step(0, 0, 1, mk(2'b10, 3'b000, 6'h01, 0, 4'b0000), "R2 mode 000");
    step(0, 0, 1, mk(2'b11, 3'b101, 6'h01, 0, 4'b0000), "R2 mode 101");
    step(0, 0, 1, mk(2'b01, 3'b001, 6'h01, 1, 4'b0000), "R2 reserved bit");
    step(0, 1, 0, 16'h0, "R9 wake in Active ignored");
    // R8 low power
    step(0, 0, 1, mk(2'b11, 3'b011, 6'h00, 0, 4'b1111), "R8 sleep forces off");
    step(0, 0, 1, mk(2'b10, 3'b001, 6'h20, 0, 4'b1111), "R10 first Active word no switches");
    step(0, 0, 1, mk(2'b10, 3'b001, 6'h20, 0, 4'b1111), "R10 second Active word applies");
    step(0, 0, 1, mk(2'b11, 3'b010, 6'h00, 0, 4'b1111), "R8 lin sleep");
    step(0, 1, 0, 16'h0, "R9 wake sets pending");
    step(0, 1, 0, 16'h0, "R9 second wake");
    step(0, 0, 1, mk(2'b11, 3'b001, 6'h00, 0, 4'b0011), "R10 Active clears pending");
    step(0, 0, 1, mk(2'b11, 3'b110, 6'h00, 0, 4'b0011), "R6 R7 rx-only applies switches");
    step(0, 1, 0, 16'h0, "R9 wake in rx-only ignored");
    step(0, 1, 1, mk(2'b01, 3'b111, 6'h07, 0, 4'b1111), "R9 R6 word beats wake, stop");
    step(0, 1, 1, mk(2'b00, 3'b001, 6'h00, 0, 4'b1111), "R9 wake with bad word");
    step(0, 0, 1, mk(2'b11, 3'b110, 6'h00, 0, 4'b1111), "R10 rx-only while disarmed");
    step(0, 0, 1, mk(2'b10, 3'b011, 6'h05, 0, 4'b0000), "R8 sleep again");
    step(1, 0, 1, mk(2'b01, 3'b110, 6'h1f, 0, 4'b1111), "R11 soft reset retains");
    step(0, 0, 1, mk(2'b11, 3'b001, 6'h00, 0, 4'b1001), "R11 armed after soft reset");
    step(0, 0, 1, mk(2'b01, 3'b001, 6'h15, 0, 4'b1001), "R3 wake cfg mon off");
    step(1, 0, 0, 16'h0, "R11 soft reset again");
    idle("R6 settle");
    idle("R6 settle");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule